// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block turns one burst request into the column address for each data beat of a DDR burst. A request gives a starting column, a length code that selects 2, 4 or 8 beats, and an ordering mode. The block then produces one column address per clock together with a valid flag and a flag that marks the final beat. Reads and writes use the same ordering rules, so the block serves both.

Each burst covers an aligned block of BL columns. The column bits above the low log2(BL) bits come from the starting column and stay fixed for the whole burst. The low bits step through the block. In sequential mode they count upward and wrap modulo BL. In interleaved mode beat i uses the starting offset XOR i. An early-stop input ends the current burst. A new accepted request in the middle of a burst discards the old burst and starts again from the new column.

Top module: `ddr_burst_colgen`

## Requirements
- R1: After reset, and until a request is accepted, `valid_o` and `last_o` are low.
- R2: When `start_i` is high with a legal length code at a rising edge, the next cycle shows `valid_o` high and `col_o` equal to the requested column (beat 0).
- R3: Length code 0 gives 2 beats, 1 gives 4 beats and 2 gives 8 beats. With no stop and no new request, `valid_o` stays high for exactly that many consecutive cycles. `last_o` is high only on the final beat.
- R4: On every beat, the bits of `col_o` above the low log2(BL) bits equal those bits of the requested column.
- R5: With `order_i` = 0 (sequential), beat i carries low bits (start + i) mod BL.
- R6: With `order_i` = 1 (interleaved), beat i carries low bits start XOR i.
- R7: For a 2-beat burst, both orderings produce the same sequence: 0-1 when the start offset is even and 1-0 when it is odd.
- R8: A high `stop_i` at an edge during a burst, with no accepted request at that edge, makes `valid_o` low in the next cycle. While idle, `stop_i` has no effect.
- R9: A request accepted during a burst aborts that burst, and the next cycle shows beat 0 of the new request. A request wins over `stop_i` when both are high at the same edge.
- R10: A request with length code 3 is ignored. A burst in progress continues unchanged, and an idle block stays idle.
- R11: After the final beat, `valid_o` is low unless a request was accepted at that edge. A request accepted on the final beat gives back-to-back bursts with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Burst request pulse |
| start_col_i | input | COL_W | Starting column of the request |
| blen_i | input | 2 | Length code: 0=2, 1=4, 2=8 beats, 3=ignored |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Ends the current burst early |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is present on `col_o` |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
Directed bursts place the start offset at zero, at mid-block values and at the top of the block, for every length and both orderings. Sequential and interleaved results differ for most of these starts, so a swapped or mixed-up ordering shows up. Starts with non-zero upper bits show whether the wrap stays inside the block instead of carrying into the upper bits. A long random stream adds overlapping requests, stops, reserved length codes and starts on the final beat. This stream tells abort and restart handling apart from an ordinary burst ending.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;

  typedef enum logic [1:0] {
    BLEN_2   = 2'd0,
    BLEN_4   = 2'd1,
    BLEN_8   = 2'd2,
    BLEN_RSV = 2'd3
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } order_e;

  localparam int unsigned LOW_W = 3;

  // Mask of the low column bits that move within the block; also BL-1.
  function automatic logic [LOW_W-1:0] block_mask(input logic [1:0] code);
    case (code)
      2'd0:    block_mask = 3'd1;
      2'd1:    block_mask = 3'd3;
      default: block_mask = 3'd7;
    endcase
  endfunction

  // Low bits for a given beat of a burst.
  function automatic logic [LOW_W-1:0] beat_offset(
    input logic [LOW_W-1:0] start_low,
    input logic [LOW_W-1:0] beat,
    input logic [1:0]       code,
    input logic             ord
  );
    logic [LOW_W-1:0] sum;
    logic [LOW_W-1:0] mix;
    sum = start_low + beat;
    mix = start_low ^ beat;
    beat_offset = (ord ? mix : sum) & block_mask(code);
  endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import ddr_burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [1:0]       blen_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic [LOW_W-1:0] beat_o,
  output logic [1:0]       blen_o,
  output logic             final_o
);

  logic             active_q;
  logic [LOW_W-1:0] beat_q;
  logic [1:0]       blen_q;

  assign final_o = active_q && (beat_q == block_mask(blen_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      blen_q   <= 2'd0;
    end else if (accept_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      blen_q   <= blen_i;
    end else if (active_q && stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (final_o) active_q <= 1'b0;
      else         beat_q   <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign blen_o   = blen_q;

endmodule

// File: rtl/burst_ctx_reg.sv
module burst_ctx_reg #(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             ord_i,
  output logic [COL_W-1:0] col_o,
  output logic             ord_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_o <= '0;
      ord_o <= 1'b0;
    end else if (load_i) begin
      col_o <= col_i;
      ord_o <= ord_i;
    end
  end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import ddr_burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_col_i,
  input  logic [LOW_W-1:0] beat_i,
  input  logic [1:0]       blen_i,
  input  logic             ord_i,
  output logic [COL_W-1:0] col_o
);

  logic [LOW_W-1:0] off_w;
  logic [LOW_W-1:0] mask_w;

  assign off_w  = beat_offset(base_col_i[LOW_W-1:0], beat_i, blen_i, ord_i);
  assign mask_w = block_mask(blen_i);

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < LOW_W) begin : g_low
      assign col_o[b] = mask_w[b] ? off_w[b] : base_col_i[b];
    end else begin : g_high
      assign col_o[b] = base_col_i[b];
    end
  end

endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
  import ddr_burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             order_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic             accept_w;
  logic             active_w;
  logic [LOW_W-1:0] beat_w;
  logic [1:0]       blen_q_w;
  logic             final_w;
  logic [COL_W-1:0] base_col_w;
  logic             ord_w;

  assign accept_w = start_i && (blen_i != BLEN_RSV);

  burst_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_w),
    .blen_i   (blen_i),
    .stop_i   (stop_i),
    .active_o (active_w),
    .beat_o   (beat_w),
    .blen_o   (blen_q_w),
    .final_o  (final_w)
  );

  burst_ctx_reg #(.COL_W(COL_W)) u_ctx (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept_w),
    .col_i  (start_col_i),
    .ord_i  (order_i),
    .col_o  (base_col_w),
    .ord_o  (ord_w)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_col_i (base_col_w),
    .beat_i     (beat_w),
    .blen_i     (blen_q_w),
    .ord_i      (ord_w),
    .col_o      (col_o)
  );

  assign valid_o = active_w;
  assign last_o  = final_w;

endmodule

// File: rtl/ddr_burst_colgen_chk.sv
module ddr_burst_colgen_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             accept_w,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (valid_o && col_o == $past(start_col_i)));

  assert_last_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  assert_continue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !stop_i && !accept_w) |=> valid_o);

  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && !$past(accept_w)) |-> $stable(col_o[COL_W-1:3]));

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && stop_i && !accept_w) |=> !valid_o);

  assert_end_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !accept_w) |=> !valid_o);

endmodule

bind ddr_burst_colgen ddr_burst_colgen_chk #(.COL_W(COL_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_i      (stop_i),
  .start_col_i (start_col_i),
  .accept_w    (accept_w),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/ddr_burst_colgen_tb.sv
module ddr_burst_colgen_tb_top;
  localparam int COL_W  = 10;
  localparam int CLK_PS = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [1:0]       blen_i = 2'd0;
  logic             order_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  bit         m_act = 0;
  int         m_beat = 0;
  int         m_col = 0;
  int         m_len = 0;
  bit         m_xor = 0;

  always #(CLK_PS/2) clk = ~clk;

  ddr_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .order_i(order_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int beats_of(int code);
    return 2 << code;
  endfunction

  function automatic int want_col(int scol, int beat, int code, bit xo);
    int n, s, off;
    n = beats_of(code);
    s = scol % n;
    if (xo) off = s ^ beat;
    else    off = (s + beat) % n;
    return scol - s + off;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_now(string tag);
    string tc, tv;
    tc = (tag != "") ? tag : (m_xor ? "R6" : "R5");
    tv = (tag != "") ? tag : "R3";
    cmp(tv, "valid", int'(valid_o), int'(m_act));
    cmp(tv, "last", int'(last_o), int'(m_act && m_beat == beats_of(m_len) - 1));
    if (m_act) cmp(tc, "col", int'(col_o), want_col(m_col, m_beat, m_len, m_xor));
  endtask

  task automatic cycle(bit st, int col, int len, bit xo, bit sp, string tag);
    @(negedge clk);
    start_i = st; start_col_i = COL_W'(col); blen_i = 2'(len);
    order_i = xo; stop_i = sp;
    @(posedge clk);
    if (st && len != 3) begin
      m_act = 1; m_beat = 0; m_col = col; m_len = len; m_xor = xo;
    end else if (m_act && sp) begin
      m_act = 0;
    end else if (m_act) begin
      if (m_beat == beats_of(m_len) - 1) m_act = 0;
      else m_beat++;
    end
    #1;
    check_now(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PS * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", "valid in reset", int'(valid_o), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2, "R1");

    cycle(1, 10'h2A5, 2, 0, 0, "R2"); idle(8, "R5");      // 5-6-7-0-1-2-3-4
    cycle(1, 10'h3F1, 2, 1, 0, "R6"); idle(8, "R6");      // 1-0-3-2-5-4-7-6
    cycle(1, 10'h137, 2, 1, 0, "R6"); idle(8, "R6");      // top of block
    cycle(1, 10'h003, 1, 0, 0, "R3"); idle(4, "R3");
    cycle(1, 10'h1F6, 1, 1, 0, "R4"); idle(4, "R4");      // upper bits kept
    cycle(1, 10'h0FF, 0, 0, 0, "R7"); idle(2, "R7");
    cycle(1, 10'h0FF, 0, 1, 0, "R7"); idle(2, "R7");
    cycle(1, 10'h100, 0, 1, 0, "R7"); idle(2, "R7");
    // early stop, and stop while idle
    cycle(1, 10'h044, 2, 0, 0, "R8"); idle(2, "R8");
    cycle(0, 0, 0, 0, 1, "R8"); idle(1, "R8");
    cycle(0, 0, 0, 0, 1, "R8"); idle(1, "R8");
    // restart mid burst, start beats stop
    cycle(1, 10'h210, 2, 0, 0, "R9"); idle(2, "R9");
    cycle(1, 10'h0C9, 1, 1, 0, "R9"); idle(1, "R9");
    cycle(1, 10'h355, 2, 0, 1, "R9"); idle(8, "R9");
    // reserved length ignored
    cycle(1, 10'h012, 2, 0, 0, "R10"); idle(1, "R10");
    cycle(1, 10'h3FF, 3, 1, 0, "R10"); idle(7, "R10");
    cycle(1, 10'h3FF, 3, 1, 0, "R10"); idle(1, "R10");
    // back to back on final beat, then idle after last
    cycle(1, 10'h08E, 1, 0, 0, "R11"); idle(2, "R11");
    cycle(1, 10'h0A1, 0, 1, 0, "R11"); idle(3, "R11");

    for (int i = 0; i < 2000; i++) begin
      bit st, sp, xo;
      int col, len;
      st  = ($urandom % 6) == 0;
      sp  = ($urandom % 12) == 0;
      xo  = 1'($urandom % 2);
      len = int'($urandom % 4);
      col = int'($urandom % (1 << COL_W));
      cycle(st, col, len, xo, sp, "");
    end
    idle(10, "");
    finish_run();
  end
endmodule